// File: doc/BRIEF.md
# Radix-2 In-Place Butterfly Engine

This block runs the radix-2 decimation-in-time butterflies of an in-place FFT whose working data sits in two single-port memory banks. For each butterfly it reads operand A from one bank and operand B from the other, in the same cycle. It multiplies B by a complex twiddle W and writes A+B·W and A−B·W back to the two locations it read from. Every butterfly occupies exactly three cycles: a read cycle, an arithmetic cycle and a write cycle.

An external address generator supplies, for the butterfly index the engine presents, the two bank addresses, the bank that holds A, and the twiddle. Butterflies are issued in pairs. The two reads of a pair take two consecutive cycles, and the two writes take the next two cycles. A bank therefore serves exactly one access per cycle and never a read and a write together. The arithmetic stage is busy one cycle in two. A start pulse launches a pass of `NBF` butterflies. Busy covers the pass, and a one-cycle done marks its end.

Top module: `bfly_engine`

## Requirements
- R1: Data words pack the real part in bits [31:16] and the imaginary part in [15:0], both signed 16-bit. The twiddle packs a signed 8-bit real part in [15:8] and a signed 8-bit imaginary part in [7:0], weighted 2^-7. Each product part (B·W, full precision) is shifted arithmetically right by 7 bits. The engine then writes A+B·W to A's location and A−B·W to B's location.
- R2: Each result part that leaves the signed 16-bit range is clamped to 32767 or −32768 instead of wrapping.
- R3: In a read cycle both banks are enabled with write-enable low. The bank named by `ag_a_bank` gets `ag_addr_a` and the other bank gets `ag_addr_b`. That butterfly's results are written exactly two cycles later to the same bank addresses.
- R4: While busy, the cycles run in groups of four. Cycles 0 and 1 of a group are read cycles and cycles 2 and 3 are write cycles, and no cycle carries both a read and a write.
- R5: `bf_issue` is high in each read cycle, and `bf_idx` then shows the butterfly number, which starts at 0 and rises by one per issue up to `NBF`−1.
- R6: After a start pulse sampled while idle, `busy` is high for exactly 2·`NBF` cycles. In the following cycle `done` is high for one cycle and `busy` is low.
- R7: A start pulse while busy is ignored: the pass keeps its length and no second pass follows.
- R8: After reset `busy`, `done`, `bf_issue`, the bank enables and the bank write-enables are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a pass when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| bf_issue | output | 1 | Read cycle of a butterfly |
| bf_idx | output | CW | Butterfly number being issued |
| ag_addr_a | input | AW | Bank address of operand A |
| ag_addr_b | input | AW | Bank address of operand B |
| ag_a_bank | input | 1 | Bank holding operand A |
| ag_tw | input | 2·TW | Twiddle {re, im} |
| mem_en | output | 2 | Per-bank access enable |
| mem_we | output | 2 | Per-bank write enable |
| mem_addr | output | 2·AW | Per-bank address |
| mem_wdata | output | 2·2·DW | Per-bank write data |
| mem_rdata | input | 2·2·DW | Per-bank read data, one cycle after the read |

## Verification
A slip in the phase counter shows within one cycle: `bf_issue` or `mem_we` appears at the wrong position within a group of four. A slip in the issue count shows as a wrong `bf_idx` at the next read, or as a pass length other than 2·`NBF`. A wrong bank select or a stale stage register shows at the write two cycles after its read, either as an address mismatch or as a wrong value at the end of the pass. Arithmetic faults show up when memory is compared with a sequential model after each pass. The sweep exercises clamping with extreme operands and twiddles.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
   typedef enum logic [1:0] {
      PH_RD0 = 2'd0,
      PH_RD1 = 2'd1,
      PH_WR0 = 2'd2,
      PH_WR1 = 2'd3
   } phase_t;
endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
   parameter int DW = 16,
   parameter int TW = 8,
   parameter int SH = 7,
   localparam int MW = DW + TW,
   localparam int PW = MW + 1 - SH
) (
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   input  logic signed [TW-1:0] w_re,
   input  logic signed [TW-1:0] w_im,
   output logic signed [PW-1:0] p_re,
   output logic signed [PW-1:0] p_im
);
   generate
      if (SH < 0 || SH >= MW) begin : g_bad_shift
         $error("bfly_cmul: shift out of range");
      end
   endgenerate

   logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
   logic signed [MW:0]   f_re, f_im;

   assign m_rr = b_re * w_re;
   assign m_ii = b_im * w_im;
   assign m_ri = b_re * w_im;
   assign m_ir = b_im * w_re;

   assign f_re = {m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii};
   assign f_im = {m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir};

   // dropping the low SH bits is an arithmetic right shift
   assign p_re = f_re[MW:SH];
   assign p_im = f_im[MW:SH];
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
   parameter int DW = 16,
   parameter int PW = 18,
   localparam int XW = ((PW > DW) ? PW : DW) + 1
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [PW-1:0] p_re,
   input  logic signed [PW-1:0] p_im,
   output logic [DW-1:0]        s_re,
   output logic [DW-1:0]        s_im,
   output logic [DW-1:0]        d_re,
   output logic [DW-1:0]        d_im
);
   localparam logic signed [XW-1:0] MAXV = {{(XW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [XW-1:0] MINV = {{(XW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   generate
      if (DW < 4) begin : g_bad_width
         $error("bfly_addsub: data width too small");
      end
   endgenerate

   function automatic logic [DW-1:0] clip(input logic signed [XW-1:0] v);
      if (v > MAXV)      return MAXV[DW-1:0];
      else if (v < MINV) return MINV[DW-1:0];
      else               return v[DW-1:0];
   endfunction

   logic signed [XW-1:0] ax_re, ax_im, px_re, px_im;
   logic signed [XW-1:0] sum_re, sum_im, dif_re, dif_im;

   assign ax_re = {{(XW-DW){a_re[DW-1]}}, a_re};
   assign ax_im = {{(XW-DW){a_im[DW-1]}}, a_im};
   assign px_re = {{(XW-PW){p_re[PW-1]}}, p_re};
   assign px_im = {{(XW-PW){p_im[PW-1]}}, p_im};

   assign sum_re = ax_re + px_re;
   assign sum_im = ax_im + px_im;
   assign dif_re = ax_re - px_re;
   assign dif_im = ax_im - px_im;

   assign s_re = clip(sum_re);
   assign s_im = clip(sum_im);
   assign d_re = clip(dif_re);
   assign d_im = clip(dif_im);
endmodule

// File: rtl/bfly_sched.sv
module bfly_sched
   import bfly_pkg::*;
#(
   parameter int NBF = 1024,
   localparam int CW = $clog2(NBF + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          issue,
   output logic [CW-1:0] idx
);
   generate
      if (NBF < 2 || (NBF % 2) != 0) begin : g_bad_count
         $error("bfly_sched: butterfly count must be even and at least 2");
      end
   endgenerate

   phase_t        ph;
   logic [CW-1:0] cnt;
   logic          last;

   assign issue = busy && (ph == PH_RD0 || ph == PH_RD1) && (cnt < CW'(NBF));
   assign idx   = cnt;
   assign last  = (ph == PH_WR1) && (cnt == CW'(NBF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         ph   <= PH_RD0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               ph   <= PH_RD0;
               cnt  <= '0;
            end
         end else begin
            ph <= phase_t'(ph + 2'd1);
            if (issue) cnt <= cnt + 1'b1;
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !last) |=> busy);
endmodule

// File: rtl/bfly_engine.sv
module bfly_engine #(
   parameter int DW  = 16,
   parameter int TW  = 8,
   parameter int SH  = TW - 1,
   parameter int AW  = 10,
   parameter int NBF = 1024,
   localparam int CW = $clog2(NBF + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      busy,
   output logic                      done,
   output logic                      bf_issue,
   output logic [CW-1:0]             bf_idx,
   input  logic [AW-1:0]             ag_addr_a,
   input  logic [AW-1:0]             ag_addr_b,
   input  logic                      ag_a_bank,
   input  logic [2*TW-1:0]           ag_tw,
   output logic [1:0]                mem_en,
   output logic [1:0]                mem_we,
   output logic [1:0][AW-1:0]        mem_addr,
   output logic [1:0][2*DW-1:0]      mem_wdata,
   input  logic [1:0][2*DW-1:0]      mem_rdata
);
   localparam int PW = DW + TW + 1 - SH;

   generate
      if (AW < 1) begin : g_bad_addr
         $error("bfly_engine: address width must be positive");
      end
   endgenerate

   // control
   bfly_sched #(.NBF(NBF)) u_sched (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .issue (bf_issue),
      .idx   (bf_idx)
   );

   // compute stage registers (loaded in the read cycle)
   logic            cp_v, cp_sel;
   logic [AW-1:0]   cp_aa, cp_ab;
   logic [2*TW-1:0] cp_w;
   // write stage registers (loaded in the compute cycle)
   logic            wr_v, wr_sel;
   logic [AW-1:0]   wr_aa, wr_ab;
   logic [2*DW-1:0] wr_ra, wr_rb;

   logic [2*DW-1:0]      a_word, b_word;
   logic signed [PW-1:0] p_re, p_im;
   logic [DW-1:0]        s_re, s_im, d_re, d_im;

   assign a_word = mem_rdata[cp_sel];
   assign b_word = mem_rdata[~cp_sel];

   bfly_cmul #(.DW(DW), .TW(TW), .SH(SH)) u_cmul (
      .b_re (b_word[2*DW-1:DW]),
      .b_im (b_word[DW-1:0]),
      .w_re (cp_w[2*TW-1:TW]),
      .w_im (cp_w[TW-1:0]),
      .p_re (p_re),
      .p_im (p_im)
   );

   bfly_addsub #(.DW(DW), .PW(PW)) u_addsub (
      .a_re (a_word[2*DW-1:DW]),
      .a_im (a_word[DW-1:0]),
      .p_re (p_re),
      .p_im (p_im),
      .s_re (s_re),
      .s_im (s_im),
      .d_re (d_re),
      .d_im (d_im)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cp_v <= 1'b0;
         wr_v <= 1'b0;
      end else begin
         cp_v <= bf_issue;
         wr_v <= cp_v;
      end
   end

   always_ff @(posedge clk) begin
      if (bf_issue) begin
         cp_sel <= ag_a_bank;
         cp_aa  <= ag_addr_a;
         cp_ab  <= ag_addr_b;
         cp_w   <= ag_tw;
      end
      if (cp_v) begin
         wr_sel <= cp_sel;
         wr_aa  <= cp_aa;
         wr_ab  <= cp_ab;
         wr_ra  <= {s_re, s_im};
         wr_rb  <= {d_re, d_im};
      end
   end

   // bank ports
   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         assign mem_en[b]    = bf_issue | wr_v;
         assign mem_we[b]    = wr_v;
         assign mem_addr[b]  = wr_v ? ((wr_sel == 1'(b)) ? wr_aa : wr_ab)
                                    : ((ag_a_bank == 1'(b)) ? ag_addr_a : ag_addr_b);
         assign mem_wdata[b] = (wr_sel == 1'(b)) ? wr_ra : wr_rb;

         // R3
         inplace_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we[b] |-> (mem_addr[b] == $past(mem_addr[b], 2)));
      end
   endgenerate

   // R4
   rw_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bf_issue && wr_v));
   // R3
   wb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we[0] |-> $past(bf_issue, 2));
   // R5
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bf_issue |=> (bf_idx == CW'($past(bf_idx) + 1'b1)));
endmodule

// File: tb/bfly_engine_test.sv
module bfly_engine_test;
   localparam int DW  = 16;
   localparam int TW  = 8;
   localparam int AW  = 3;
   localparam int D   = 8;
   localparam int NBF = 8;
   localparam int CW  = $clog2(NBF + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   always #4 clk = ~clk;

   logic                 busy, done, bf_issue;
   logic [CW-1:0]        bf_idx;
   logic [AW-1:0]        ag_addr_a, ag_addr_b;
   logic                 ag_a_bank;
   logic [2*TW-1:0]      ag_tw;
   logic [1:0]           mem_en, mem_we;
   logic [1:0][AW-1:0]   mem_addr;
   logic [1:0][2*DW-1:0] mem_wdata;
   logic [1:0][2*DW-1:0] mem_rdata;

   bfly_engine #(.DW(DW), .TW(TW), .AW(AW), .NBF(NBF)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .bf_issue(bf_issue), .bf_idx(bf_idx), .ag_addr_a(ag_addr_a),
      .ag_addr_b(ag_addr_b), .ag_a_bank(ag_a_bank), .ag_tw(ag_tw),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int tests = 0;
   int fails = 0;
   bit finished = 0;
   int cur_t = 0;
   logic [31:0] rs = 32'h1234_5678;

   logic [31:0] mem [2][D];
   logic [31:0] sh  [2][D];

   function automatic int bank_of(int t, int k);
      case (t % 3)
         0:       return k % 2;
         1:       return 0;
         default: return ((k >> 1) ^ k) & 1;
      endcase
   endfunction

   function automatic int off_of(int t);
      case (t % 3)
         0:       return 0;
         1:       return 3;
         default: return 5;
      endcase
   endfunction

   function automatic logic [15:0] tw_of(int t, int k);
      if (t == 1) return 16'h7F00;
      if (t == 2) return 16'h8080;
      return {8'(k * 73 + t * 29 + 5), 8'(k * 151 + t * 17 + 90)};
   endfunction

   function automatic int clamp(int v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   // address generator model
   always_comb begin
      ag_addr_a = AW'(int'(bf_idx));
      ag_addr_b = AW'(int'(bf_idx) + off_of(cur_t));
      ag_a_bank = bank_of(cur_t, int'(bf_idx)) != 0;
      ag_tw     = tw_of(cur_t, int'(bf_idx));
   end

   // single-port bank models, one-cycle read latency
   always @(posedge clk) begin
      for (int b = 0; b < 2; b++) begin
         if (mem_en[b]) begin
            if (mem_we[b]) mem[b][mem_addr[b]] <= mem_wdata[b];
            else           mem_rdata[b] <= mem[b][mem_addr[b]];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic next_rnd();
      rs = rs * 32'd1664525 + 32'd1013904223;
   endtask

   task automatic ref_pass(input int t);
      for (int k = 0; k < NBF; k++) begin
         int sa, sb, ia, ib, ar, ai, br, bi, wr, wi, pr, pi;
         logic [15:0] w;
         sa = bank_of(t, k);
         sb = 1 - sa;
         ia = k;
         ib = (k + off_of(t)) % D;
         w  = tw_of(t, k);
         ar = int'($signed(sh[sa][ia][31:16]));
         ai = int'($signed(sh[sa][ia][15:0]));
         br = int'($signed(sh[sb][ib][31:16]));
         bi = int'($signed(sh[sb][ib][15:0]));
         wr = int'($signed(w[15:8]));
         wi = int'($signed(w[7:0]));
         pr = (br * wr - bi * wi) >>> 7;
         pi = (br * wi + bi * wr) >>> 7;
         sh[sa][ia] = {16'(clamp(ar + pr)), 16'(clamp(ai + pi))};
         sh[sb][ib] = {16'(clamp(ar - pr)), 16'(clamp(ai - pi))};
      end
   endtask

   task automatic run_pass(input int t);
      string rq;
      @(negedge clk);
      cur_t = t;
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < D; i++) begin
            if (t == 1)
               mem[b][i] = ((i + b) % 2 == 0) ? {16'h7FFF, 16'h8000} : {16'h8000, 16'h7FFF};
            else begin
               next_rnd();
               mem[b][i] = rs;
            end
            sh[b][i] = mem[b][i];
         end
      end
      ref_pass(t);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 2 * NBF + 2; c++) begin
         if (t == 4 && c == 5) start = 1'b1;
         if (t == 4 && c == 6) start = 1'b0;
         if (c < 2 * NBF) begin
            int k, sa, ph;
            ph = c % 4;
            chk(busy == 1'b1, "R6", "busy during pass", busy, 1);
            chk(bf_issue == (ph < 2), "R4", "issue position", bf_issue, ph < 2);
            chk(mem_en == 2'b11, "R4", "bank enables", mem_en, 3);
            chk(mem_we == ((ph >= 2) ? 2'b11 : 2'b00), "R4", "write position",
                mem_we, (ph >= 2) ? 3 : 0);
            k  = (c / 4) * 2 + ((ph < 2) ? ph : ph - 2);
            sa = bank_of(t, k);
            if (ph < 2) chk(int'(bf_idx) == k, "R5", "butterfly index", bf_idx, k);
            chk(int'(mem_addr[sa]) == k, "R3", "A address", mem_addr[sa], k);
            chk(int'(mem_addr[1-sa]) == (k + off_of(t)) % D, "R3", "B address",
                mem_addr[1-sa], (k + off_of(t)) % D);
         end else if (c == 2 * NBF) begin
            chk(done == 1'b1, "R6", "done pulse", done, 1);
            chk(busy == 1'b0, "R6", "busy after pass", busy, 0);
         end else begin
            chk(done == 1'b0, "R6", "done one cycle", done, 0);
            chk(busy == 1'b0, t == 4 ? "R7" : "R6", "no restart", busy, 0);
         end
         @(posedge clk);
         @(negedge clk);
      end
      rq = (t == 1 || t == 2) ? "R2" : "R1";
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < D; i++)
            chk(mem[b][i] === sh[b][i], rq, "result word", mem[b][i], sh[b][i]);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8 reset state
      chk(busy == 1'b0, "R8", "busy in reset", busy, 0);
      chk(done == 1'b0, "R8", "done in reset", done, 0);
      chk(bf_issue == 1'b0, "R8", "issue in reset", bf_issue, 0);
      chk(mem_en == 2'b00 && mem_we == 2'b00, "R8", "bank enables in reset", mem_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && mem_en == 2'b00, "R8", "idle after reset", busy, 0);
      for (int t = 0; t < 6; t++) run_pass(t);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule